// File: doc/BRIEF.md
# Edge-Triggered Three-State Phase-Frequency Detector

This block compares the rising edges of an external signal A with those of a reference signal B, which in a synthesizer comes from a local divider. Its charge-pump output has three levels: pushed high, pulled low, or released. The output is encoded as a drive enable and a drive level. When A's edge comes first, the output pushes high until B's edge arrives. When B's edge comes first, the output pulls low until A's edge arrives. Between these pulses the output is released. A loop filter placed after the block then settles the oscillator until the two edge trains line up.

Both inputs are asynchronous to the system clock. Each one passes through a parameterised flop synchronizer and a rising-edge detector, so all state changes happen on the system clock. The state machine responds only to detected rising edges. A lock flag reports that no pump pulse is in progress. With the default two-flop synchronizer, an input change reaches the outputs on the third rising clock edge after it is applied.

Top module: `pfd_lock_top`

## Requirements
- R1: A synchronous reset, held high across a clock edge, leaves the outputs released: `pump_en`=0, `pump_lvl`=0, `lock_flag`=1.
- R2: While released, a rising edge on `sig_a` with no rising edge on `sig_b` in the same sampled cycle makes the output push high (`pump_en`=1, `pump_lvl`=1). This takes effect on the third clock edge after the input changes.
- R3: While released, a rising edge on `sig_b` alone makes the output pull low (`pump_en`=1, `pump_lvl`=0), with the same latency as R2.
- R4: A rising edge on `sig_b` ends a high pulse, and a rising edge on `sig_a` ends a low pulse. In both cases the output returns to released.
- R5: Further rising edges on `sig_a` during a high pulse keep it high, and further rising edges on `sig_b` during a low pulse keep it low. So a faster A gives high drive and a faster B gives low drive.
- R6: Falling edges, and how long either input stays high, never change the output state.
- R7: Rising edges of A and B detected in the same sampled cycle count as coincident. The output goes to, or stays, released, with no pulse.
- R8: The output never goes directly between high and low. It always passes through released, and `pump_lvl` is 0 whenever `pump_en` is 0.
- R9: `lock_flag` is 1 exactly when the output is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_a | input | 1 | External compared signal A (asynchronous) |
| sig_b | input | 1 | Reference signal B (asynchronous) |
| pump_en | output | 1 | 1 while the pump output is driven |
| pump_lvl | output | 1 | Driven level: 1 high, 0 low; 0 when released |
| lock_flag | output | 1 | 1 while no pump pulse is in progress |

## Verification
An input level applied between clock edges moves through two synchronizer flops and the edge-history flop. The state register then updates on the third rising edge, and all outputs are decoded directly from that register. The bench drives inputs on falling clock edges and computes the expected state for each drive from its own model of the transition rules. It holds that expected state in a three-entry delay line and compares it against the outputs at the falling edge three cycles later. Every comparison is tagged with the rule that applied to the transition being checked.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_UP   = 2'd1,
    PS_DN   = 2'd2
  } pfd_state_e;

  // Next state from the current state and the two edge events of one cycle.
  function automatic pfd_state_e pfd_step(pfd_state_e cur, logic ra, logic rb);
    pfd_state_e nxt;
    nxt = cur;
    if (ra && rb) begin
      nxt = PS_IDLE;
    end else begin
      case (cur)
        PS_IDLE: nxt = ra ? PS_UP : (rb ? PS_DN : PS_IDLE);
        PS_UP:   nxt = rb ? PS_IDLE : PS_UP;
        PS_DN:   nxt = ra ? PS_IDLE : PS_DN;
        default: nxt = PS_IDLE;
      endcase
    end
    return nxt;
  endfunction

  function automatic logic drive_en(pfd_state_e st);
    return (st == PS_UP) || (st == PS_DN);
  endfunction

  function automatic logic drive_lvl(pfd_state_e st);
    return st == PS_UP;
  endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= '0;
    else     pipe_q <= {pipe_q[DEPTH-2:0], din};
  end

  assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];

  // R6: an edge event is a single-cycle pulse; a held level gives no second event.
  p_rise_single_r6: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

endmodule

// File: rtl/pfd_fsm.sv
module pfd_fsm
  import pfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rise_a,
  input  logic       rise_b,
  output pfd_state_e state
);
  pfd_state_e state_q;
  logic       ev_coincident;
  logic       ev_none;

  assign ev_coincident = rise_a & rise_b;
  assign ev_none       = ~rise_a & ~rise_b;

  always_ff @(posedge clk) begin
    if (rst) state_q <= PS_IDLE;
    else     state_q <= pfd_step(state_q, rise_a, rise_b);
  end

  assign state = state_q;

  p_up_from_a_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_IDLE && rise_a && !rise_b) |=> state_q == PS_UP);

  p_dn_from_b_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_IDLE && rise_b && !rise_a) |=> state_q == PS_DN);

  p_up_ends_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_UP && rise_b) |=> state_q == PS_IDLE);

  p_dn_ends_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_DN && rise_a) |=> state_q == PS_IDLE);

  p_hold_no_edge_r6: assert property (@(posedge clk) disable iff (rst)
    ev_none |=> $stable(state_q));

  p_coincident_r7: assert property (@(posedge clk) disable iff (rst)
    ev_coincident |=> state_q == PS_IDLE);

  p_no_direct_swap_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_UP) |=> state_q != PS_DN);

endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
  import pfd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_a,
  input  logic sig_b,
  output logic pump_en,
  output logic pump_lvl,
  output logic lock_flag
);
  localparam int NCH = 2;

  logic [NCH-1:0] raw_in;
  logic [NCH-1:0] rise_v;
  pfd_state_e     cur_state;

  assign raw_in = {sig_b, sig_a};

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (raw_in[g]),
      .rise (rise_v[g])
    );
  end

  pfd_fsm u_fsm (
    .clk    (clk),
    .rst    (rst),
    .rise_a (rise_v[0]),
    .rise_b (rise_v[1]),
    .state  (cur_state)
  );

  assign pump_en   = drive_en(cur_state);
  assign pump_lvl  = drive_lvl(cur_state);
  assign lock_flag = (cur_state == PS_IDLE);

  // R8: released output carries level 0; a high pulse never turns straight into low.
  p_lvl_released_r8: assert property (@(posedge clk) disable iff (rst)
    !pump_en |-> !pump_lvl);

  p_pulse_polarity_r8: assert property (@(posedge clk) disable iff (rst)
    (pump_en && pump_lvl) |=> (!pump_en || pump_lvl));

endmodule

// File: tb/pfd_lock_top_tb.sv
module pfd_lock_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sig_a = 1'b0;
  logic sig_b = 1'b0;
  logic pump_en, pump_lvl, lock_flag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Bench model encoding: 0 released, 1 high, 2 low.
  int    m_state = 0;
  bit    prev_a = 0, prev_b = 0;
  int    q_st [3];
  string q_tag [3];
  int    tick = 0;

  always #4 clk = ~clk;

  pfd_lock_top dut_i (
    .clk(clk), .rst(rst), .sig_a(sig_a), .sig_b(sig_b),
    .pump_en(pump_en), .pump_lvl(pump_lvl), .lock_flag(lock_flag)
  );

  function automatic int model_next(int cur, bit ra, bit rb, output string tag);
    if (ra && rb)                 begin tag = "R7"; return 0; end
    if (!ra && !rb)               begin tag = "R6"; return cur; end
    if (cur == 0)                 begin tag = ra ? "R2" : "R3"; return ra ? 1 : 2; end
    if (cur == 1)                 begin tag = rb ? "R4" : "R5"; return rb ? 0 : 1; end
    tag = ra ? "R4" : "R5";
    return ra ? 0 : 2;
  endfunction

  function automatic bit exp_en(int st);  return st != 0; endfunction
  function automatic bit exp_lvl(int st); return st == 1; endfunction

  task automatic check_bit(string tag, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at tick %0d: actual %0b expected %0b", tag, what, tick, act, exp);
    end
  endtask

  // One cycle: sample outputs (due for drive three cycles back), then drive new inputs.
  task automatic step(bit a, bit b);
    string t;
    @(negedge clk);
    check_bit(q_tag[2], "pump_en", pump_en, exp_en(q_st[2]));
    check_bit("R8", "pump_lvl", pump_lvl, exp_lvl(q_st[2]));
    check_bit("R9", "lock_flag", lock_flag, q_st[2] == 0);
    sig_a = a;
    sig_b = b;
    m_state = model_next(m_state, a & ~prev_a, b & ~prev_b, t);
    prev_a = a;
    prev_b = b;
    q_st[2] = q_st[1];  q_tag[2] = q_tag[1];
    q_st[1] = q_st[0];  q_tag[1] = q_tag[0];
    q_st[0] = m_state;  q_tag[0] = t;
    tick++;
  endtask

  // Square waves: periods pa/pb, high times ha/hb, B delayed by offs cycles.
  task automatic run_waves(int pa, int ha, int pb, int hb, int offs, int n);
    for (int i = 0; i < n; i++) begin
      int tb_i;
      tb_i = i + pb * 8 - offs;
      step((i % pa) < ha, (tb_i % pb) < hb);
    end
  endtask

  task automatic flush();
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0);
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 3; i++) begin q_st[i] = 0; q_tag[i] = "R1"; end
    repeat (4) @(negedge clk);
    // R1: reset state
    check_bit("R1", "pump_en", pump_en, 1'b0);
    check_bit("R1", "pump_lvl", pump_lvl, 1'b0);
    check_bit("R1", "lock_flag", lock_flag, 1'b1);
    rst = 1'b0;
    // R2 / R4: equal frequency, A leads B by 3 cycles
    run_waves(16, 8, 16, 8, 3, 80);
    flush();
    // R3 / R4: equal frequency, A lags B
    run_waves(16, 8, 16, 5, -5, 80);
    flush();
    // R7: coincident edges, different duty cycles (R6)
    run_waves(12, 2, 12, 9, 0, 72);
    flush();
    // R5: A faster than B -> mostly high
    run_waves(9, 4, 14, 7, 2, 120);
    flush();
    // R5: B faster than A -> mostly low
    run_waves(15, 3, 10, 5, 1, 120);
    flush();
    // R6: directed: edge of A, then A falls and rises only once more after B
    step(1,0); step(1,0); step(0,0); step(0,0); step(0,1); step(0,0);
    step(0,1); step(0,1); step(1,1); step(1,0); step(0,0); step(0,0);
    flush();
    // Mixed random stimulus
    for (int i = 0; i < 3000; i++) begin
      bit na, nb;
      na = ($urandom_range(0, 5) == 0) ? ~prev_a : prev_a;
      nb = ($urandom_range(0, 5) == 0) ? ~prev_b : prev_b;
      step(na, nb);
    end
    flush();
    // R1: reset in the middle of a pulse
    step(1,0); step(1,0); step(1,0); step(1,0);
    @(negedge clk);
    rst = 1'b1;
    sig_a = 1'b0; sig_b = 1'b0;
    @(negedge clk);
    check_bit("R1", "pump_en after reset", pump_en, 1'b0);
    check_bit("R1", "lock_flag after reset", lock_flag, 1'b1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule